// File: doc/BRIEF.md
# Sliding Window Edge Substitution

This block sits between the line buffers that assemble a square, odd-sized window of pixels over a raster stream and the filter kernel that consumes that window. Every accepted pixel produces a raw window whose newest tap is that pixel. The block follows the frame-start and line-start markers that travel with the stream. From them it works out which image pixel sits at the centre of the current window. Every tap that would lie above, below, left of or right of the image is overwritten before the window reaches the kernel. Near the left and right edges the raw window wraps into the neighbouring line, and near the top and bottom it reaches into another frame. None of that data is valid.

A runtime select chooses the substitute value. It is either the window's centre pixel, which always lies inside the image, or a constant supplied on a separate input. The corrected window is registered and appears one clock after the raw window, together with a valid flag. That flag pulses exactly once for each image pixel that becomes a window centre. Because the centre trails the newest pixel by half a window in each direction, the last centres of a frame appear while the first pixels of the next frame arrive.

Top module: `bsw_boundary_switch`

## Requirements
- R1: While reset is high, and on the first clock after it falls with no accepted pixel, `out_valid` is 0 and `out_win` is all zeros.
- R2: `out_valid` is high in the clock after an accepted pixel (`in_valid` high) only once tracking is primed. Tracking primes when the newest pixel is at column HALF, row HALF of a frame, where HALF = (WIN-1)/2. No other clock has `out_valid` high.
- R3: The centre of the window that primes tracking is image pixel (0,0). Each later accepted pixel moves the centre one step in raster order, wrapping at IMG_W columns and IMG_H rows.
- R4: The window is carried as WIN*WIN taps of PIX_W bits, with tap t = row*WIN + col in bits [t*PIX_W +: PIX_W]. Row 0 is the top and col 0 is the left. A tap whose image position (centre column + col - HALF, centre row + row - HALF) lies inside the image passes unchanged.
- R5: A tap whose column position is below 0 or above IMG_W-1 is replaced by the fill value.
- R6: A tap whose row position is below 0 or above IMG_H-1 is replaced by the fill value.
- R7: The fill value is the raw centre tap (t = HALF*WIN + HALF) when `fill_sel` is 1, and `fill_const` when `fill_sel` is 0. Both are sampled with the same pixel.
- R8: The centre tap is never replaced.
- R9: A frame-start marker on an accepted pixel resets the newest-pixel position to (0,0). The centre then resynchronises to (0,0) when the newest pixel next reaches (HALF, HALF).
- R10: In a clock without an accepted pixel, `out_valid` is 0 in the next clock and `out_win` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Raw window and markers are valid this clock |
| in_sof | input | 1 | Newest pixel is the first of a frame |
| in_sol | input | 1 | Newest pixel is the first of a line |
| in_win | input | WIN*WIN*PIX_W | Raw window from the line buffers |
| fill_sel | input | 1 | 1: substitute centre pixel, 0: substitute constant |
| fill_const | input | PIX_W | Constant substitute value |
| out_valid | output | 1 | Corrected window holds a new centre |
| out_win | output | WIN*WIN*PIX_W | Corrected window |

## Verification
Some properties are checked on every clock: the valid flag follows only an accepted pixel, an idle clock leaves the window untouched, the centre tap is copied through, and a corner tap carries either its raw value or one of the two substitute sources. Which taps are actually replaced depends on where the centre lies in the image, and only the bench scenarios show that. They cover priming in the first frame, every edge and corner for both substitute sources, gaps in the stream, and a frame restarted partway through.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
  typedef enum logic {
    FILL_CONST  = 1'b0,
    FILL_CENTRE = 1'b1
  } fill_src_e;

  // half-width of an odd window
  function automatic int half_of(input int win);
    return (win - 1) / 2;
  endfunction
endpackage

// File: rtl/bsw_pos_tracker.sv
// Tracks the newest pixel from the stream markers and derives the image
// position of the window centre for the pixel presented this clock.
module bsw_pos_tracker #(
  parameter int IMG_W = 64,
  parameter int IMG_H = 48,
  parameter int WIN   = 5,
  localparam int XW   = (IMG_W > 1) ? $clog2(IMG_W) : 1,
  localparam int YW   = (IMG_H > 1) ? $clog2(IMG_H) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_sol,
  output logic [XW-1:0] cur_cx,
  output logic [YW-1:0] cur_cy,
  output logic          cur_live
);
  localparam int HALF = bsw_pkg::half_of(WIN);

  logic [XW-1:0] new_x_q, new_x_d;
  logic [YW-1:0] new_y_q, new_y_d;
  logic [XW-1:0] cen_x_q;
  logic [YW-1:0] cen_y_q;
  logic          primed_q;
  logic          hit;

  // position of the pixel arriving now
  always_comb begin
    if (in_sof) begin
      new_x_d = '0;
      new_y_d = '0;
    end else if (in_sol) begin
      new_x_d = '0;
      new_y_d = new_y_q + 1'b1;
    end else begin
      new_x_d = new_x_q + 1'b1;
      new_y_d = new_y_q;
    end
  end

  assign hit = (new_x_d == XW'(HALF)) && (new_y_d == YW'(HALF));

  // centre position for the pixel arriving now
  always_comb begin
    cur_cx = cen_x_q;
    cur_cy = cen_y_q;
    if (hit) begin
      cur_cx = '0;
      cur_cy = '0;
    end else if (cen_x_q == XW'(IMG_W - 1)) begin
      cur_cx = '0;
      cur_cy = (cen_y_q == YW'(IMG_H - 1)) ? '0 : cen_y_q + 1'b1;
    end else begin
      cur_cx = cen_x_q + 1'b1;
    end
  end

  assign cur_live = in_valid && (hit || primed_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      new_x_q  <= '0;
      new_y_q  <= '0;
      cen_x_q  <= '0;
      cen_y_q  <= '0;
      primed_q <= 1'b0;
    end else if (in_valid) begin
      new_x_q <= new_x_d;
      new_y_q <= new_y_d;
      if (cur_live) begin
        cen_x_q <= cur_cx;
        cen_y_q <= cur_cy;
      end
      primed_q <= primed_q | hit;
    end
  end
endmodule

// File: rtl/bsw_edge_mask.sv
// Per-row and per-column outside-the-image flags for a centre position.
module bsw_edge_mask #(
  parameter int IMG_W = 64,
  parameter int IMG_H = 48,
  parameter int WIN   = 5,
  localparam int XW   = (IMG_W > 1) ? $clog2(IMG_W) : 1,
  localparam int YW   = (IMG_H > 1) ? $clog2(IMG_H) : 1
) (
  input  logic [XW-1:0]  cx,
  input  logic [YW-1:0]  cy,
  output logic [WIN-1:0] col_out,
  output logic [WIN-1:0] row_out
);
  localparam int HALF = bsw_pkg::half_of(WIN);

  for (genvar k = 0; k < WIN; k++) begin : g_axis
    localparam int OFS = k - HALF;
    if (OFS < 0) begin : g_low
      assign col_out[k] = int'(cx) < -OFS;
      assign row_out[k] = int'(cy) < -OFS;
    end else if (OFS > 0) begin : g_high
      assign col_out[k] = int'(cx) > (IMG_W - 1 - OFS);
      assign row_out[k] = int'(cy) > (IMG_H - 1 - OFS);
    end else begin : g_mid
      assign col_out[k] = 1'b0;
      assign row_out[k] = 1'b0;
    end
  end
endmodule

// File: rtl/bsw_tap_switch.sv
// Replaces flagged taps and registers the corrected window.
module bsw_tap_switch #(
  parameter int PIX_W = 8,
  parameter int WIN   = 5,
  localparam int TAPS = WIN * WIN,
  localparam int CTR  = bsw_pkg::half_of(WIN) * WIN + bsw_pkg::half_of(WIN)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  live,
  input  logic [TAPS*PIX_W-1:0] in_win,
  input  logic [WIN-1:0]        col_out,
  input  logic [WIN-1:0]        row_out,
  input  logic                  fill_sel,
  input  logic [PIX_W-1:0]      fill_const,
  output logic                  out_valid,
  output logic [TAPS*PIX_W-1:0] out_win
);
  bsw_pkg::fill_src_e src;
  logic [PIX_W-1:0]      fill;
  logic [TAPS*PIX_W-1:0] fixed;

  assign src  = bsw_pkg::fill_src_e'(fill_sel);
  assign fill = (src == bsw_pkg::FILL_CENTRE) ? in_win[CTR*PIX_W +: PIX_W] : fill_const;

  for (genvar r = 0; r < WIN; r++) begin : g_row
    for (genvar c = 0; c < WIN; c++) begin : g_col
      localparam int T = r * WIN + c;
      assign fixed[T*PIX_W +: PIX_W] = (row_out[r] || col_out[c]) ? fill
                                                                  : in_win[T*PIX_W +: PIX_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_win   <= '0;
    end else begin
      out_valid <= live;
      if (live) out_win <= fixed;
    end
  end
endmodule

// File: rtl/bsw_boundary_switch.sv
module bsw_boundary_switch #(
  parameter int PIX_W = 8,
  parameter int WIN   = 5,
  parameter int IMG_W = 64,
  parameter int IMG_H = 48,
  localparam int TAPS = WIN * WIN,
  localparam int XW   = (IMG_W > 1) ? $clog2(IMG_W) : 1,
  localparam int YW   = (IMG_H > 1) ? $clog2(IMG_H) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic                  in_sof,
  input  logic                  in_sol,
  input  logic [TAPS*PIX_W-1:0] in_win,
  input  logic                  fill_sel,
  input  logic [PIX_W-1:0]      fill_const,
  output logic                  out_valid,
  output logic [TAPS*PIX_W-1:0] out_win
);
  logic [XW-1:0]  cx;
  logic [YW-1:0]  cy;
  logic           live;
  logic [WIN-1:0] col_out;
  logic [WIN-1:0] row_out;

  bsw_pos_tracker #(.IMG_W(IMG_W), .IMG_H(IMG_H), .WIN(WIN)) u_track (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_sol(in_sol),
    .cur_cx(cx), .cur_cy(cy), .cur_live(live)
  );

  bsw_edge_mask #(.IMG_W(IMG_W), .IMG_H(IMG_H), .WIN(WIN)) u_mask (
    .cx(cx), .cy(cy), .col_out(col_out), .row_out(row_out)
  );

  bsw_tap_switch #(.PIX_W(PIX_W), .WIN(WIN)) u_switch (
    .clk(clk), .rst(rst), .live(live), .in_win(in_win),
    .col_out(col_out), .row_out(row_out),
    .fill_sel(fill_sel), .fill_const(fill_const),
    .out_valid(out_valid), .out_win(out_win)
  );
endmodule

// File: rtl/bsw_boundary_switch_chk.sv
module bsw_boundary_switch_chk #(
  parameter int PIX_W = 8,
  parameter int WIN   = 5,
  localparam int TAPS = WIN * WIN,
  localparam int CTR  = ((WIN - 1) / 2) * WIN + (WIN - 1) / 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic [TAPS*PIX_W-1:0] in_win,
  input logic [PIX_W-1:0]      fill_const,
  input logic                  out_valid,
  input logic [TAPS*PIX_W-1:0] out_win
);
  // R2
  valid_follows_pixel_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_win)));

  // R8
  centre_pass_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_win[CTR*PIX_W +: PIX_W] == $past(in_win[CTR*PIX_W +: PIX_W])));

  // R7
  corner_source_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_win[0 +: PIX_W] == $past(in_win[0 +: PIX_W])) ||
                   (out_win[0 +: PIX_W] == $past(fill_const)) ||
                   (out_win[0 +: PIX_W] == $past(in_win[CTR*PIX_W +: PIX_W]))));
endmodule

bind bsw_boundary_switch bsw_boundary_switch_chk #(.PIX_W(PIX_W), .WIN(WIN)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_win(in_win),
  .fill_const(fill_const), .out_valid(out_valid), .out_win(out_win)
);

// File: tb/bsw_boundary_switch_test.sv
module bsw_boundary_switch_test;
  localparam int PW   = 8;
  localparam int WIN  = 5;
  localparam int IW   = 10;
  localparam int IH   = 7;
  localparam int TAPS = WIN * WIN;
  localparam int HALF = (WIN - 1) / 2;
  localparam int CTR  = HALF * WIN + HALF;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0;
  logic [TAPS*PW-1:0] in_win = '0;
  logic               fill_sel = 1'b0;
  logic [PW-1:0]      fill_const = '0;
  logic               out_valid;
  logic [TAPS*PW-1:0] out_win;

  bsw_boundary_switch #(.PIX_W(PW), .WIN(WIN), .IMG_W(IW), .IMG_H(IH)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_sol(in_sol),
    .in_win(in_win), .fill_sel(fill_sel), .fill_const(fill_const),
    .out_valid(out_valid), .out_win(out_win)
  );

  always #4 clk = ~clk;

  int  n_vec = 0, n_bad = 0;
  bit  done = 0;
  // reference model state
  int  m_nx = 0, m_ny = 0, m_cx = 0, m_cy = 0;
  bit  m_prim = 0;
  bit  e_valid = 0;
  logic [TAPS*PW-1:0] e_win = '0;

  function automatic bit tap_outside(input int cx, input int cy, input int t);
    int x, y;
    x = cx + (t % WIN) - HALF;
    y = cy + (t / WIN) - HALF;
    return (x < 0) || (x > IW - 1) || (y < 0) || (y > IH - 1);
  endfunction

  task automatic compare();
    n_vec++;
    if (out_valid !== e_valid) begin
      n_bad++;
      $display("FAIL R2 out_valid actual=%0b expected=%0b (centre %0d,%0d)",
               out_valid, e_valid, m_cx, m_cy);
      return;
    end
    for (int t = 0; t < TAPS; t++) begin
      if (out_win[t*PW +: PW] !== e_win[t*PW +: PW]) begin
        n_bad++;
        if (t == CTR)
          $display("FAIL R8 centre tap actual=%h expected=%h", out_win[t*PW +: PW], e_win[t*PW +: PW]);
        else if (!e_valid)
          $display("FAIL R10 tap %0d held actual=%h expected=%h", t, out_win[t*PW +: PW], e_win[t*PW +: PW]);
        else if (!tap_outside(m_cx, m_cy, t))
          $display("FAIL R4 tap %0d at centre %0d,%0d actual=%h expected=%h",
                   t, m_cx, m_cy, out_win[t*PW +: PW], e_win[t*PW +: PW]);
        else if (tap_outside(m_cx, HALF, t))
          $display("FAIL R5 tap %0d at centre %0d,%0d actual=%h expected=%h",
                   t, m_cx, m_cy, out_win[t*PW +: PW], e_win[t*PW +: PW]);
        else
          $display("FAIL R6 tap %0d at centre %0d,%0d actual=%h expected=%h",
                   t, m_cx, m_cy, out_win[t*PW +: PW], e_win[t*PW +: PW]);
        return;
      end
    end
  endtask

  // one clock of stimulus, checked one clock later (R3, R7 via expected window)
  task automatic apply(input bit v, input bit sof, input bit sol,
                       input bit fsel, input logic [PW-1:0] fconst);
    logic [TAPS*PW-1:0] raw;
    logic [PW-1:0]      fill;
    bit  live;
    for (int t = 0; t < TAPS; t++) raw[t*PW +: PW] = PW'($urandom);
    e_valid = 0;
    if (v) begin
      int px, py;
      if (sof) begin px = 0; py = 0; end
      else if (sol) begin px = 0; py = m_ny + 1; end
      else begin px = m_nx + 1; py = m_ny; end
      live = 0;
      if (px == HALF && py == HALF) begin
        m_cx = 0; m_cy = 0; m_prim = 1; live = 1;
      end else if (m_prim) begin
        live = 1;
        if (m_cx == IW - 1) begin
          m_cx = 0;
          m_cy = (m_cy == IH - 1) ? 0 : m_cy + 1;
        end else m_cx = m_cx + 1;
      end
      m_nx = px; m_ny = py;
      if (live) begin
        fill = fsel ? raw[CTR*PW +: PW] : fconst;
        for (int t = 0; t < TAPS; t++)
          e_win[t*PW +: PW] = tap_outside(m_cx, m_cy, t) ? fill : raw[t*PW +: PW];
        e_valid = 1;
      end
    end
    in_valid = v; in_sof = sof; in_sol = sol; in_win = raw;
    fill_sel = fsel; fill_const = fconst;
    @(negedge clk);
    compare();
  endtask

  task automatic frame(input int lines, input int idle_pct, input int fmode,
                       input logic [PW-1:0] fconst);
    for (int y = 0; y < lines; y++)
      for (int x = 0; x < IW; x++) begin
        bit fs;
        while (($urandom % 100) < idle_pct) apply(0, 0, 0, 0, fconst);
        fs = (fmode == 2) ? bit'($urandom % 2) : bit'(fmode);
        apply(1, x == 0 && y == 0, x == 0, fs, fconst);
      end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    n_vec++;
    if (out_valid !== 1'b0 || out_win !== '0) begin
      n_bad++;
      $display("FAIL R1 reset actual valid=%0b win=%h expected valid=0 win=0", out_valid, out_win);
    end
    // R2/R3: first frame primes at newest (HALF,HALF); constant fill R7, R5, R6
    frame(IH, 0, 0, 8'hA5);
    // R7: centre fill, with gaps (R10)
    frame(IH, 30, 1, 8'h00);
    // R10: long idle stretch
    repeat (5) apply(0, 0, 0, 1, 8'h3C);
    // R9: frame cut short then restarted
    frame(3, 20, 2, 8'hFF);
    frame(IH, 20, 2, 8'h11);
    for (int k = 0; k < 4; k++) frame(IH, 25, 2, PW'($urandom));
    // flush remaining centres with the start of another frame
    frame(HALF + 1, 0, 0, 8'h5A);
    in_valid = 0;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule